// File: doc/BRIEF.md
# Backward flush-train recovery controller

This controller recovers an in-order pipeline of `NSTG` stages after a timing error, without stalling the whole pipeline in one cycle. Each stage reports an error flag and a valid bit, along with the address of the instruction it holds. When a valid stage reports an error, the controller inserts a bubble into the slot behind that stage in the same cycle. One cycle later it asks that stage to load its corrected shadow value. It then sends a flush token back toward fetch, one stage per cycle, and the token removes the younger instructions as it goes. When the token has passed stage 0, the controller asks fetch to restart at the address after the instruction that failed.

The controller is a four-state machine:
- `ST_IDLE`: no recovery is in progress.
- `ST_SEED`: the shadow value is injected and the token sits at the failing stage.
- `ST_WALK`: the token moves toward stage 0.
- `ST_RELAUNCH`: the restart request is issued.

The transitions are:
- accept: any state to `ST_SEED`, on an accepted error.
- seed-to-walk: `ST_SEED` to `ST_WALK`, when the token is above stage 0.
- seed-to-relaunch and walk-to-relaunch: to `ST_RELAUNCH`, once the token has covered stage 0.
- walk-step: `ST_WALK` to `ST_WALK`, while the token keeps moving.
- relaunch-done: `ST_RELAUNCH` to `ST_IDLE`.

The controller also gates commit from the last stage, so that no slot is retired before its error check has cleared.

Top module: `flush_recovery_ctrl`

## Requirements
- R1: When an error in valid stage k is accepted, `kill_o[k+1]` is high in that same cycle. Bit i of `kill_o` refers to stage i. If k is the last stage, no bubble is raised.
- R2: In the cycle after an error is accepted, `inject_o` is high for one cycle and `inject_id_o` equals k.
- R3: The flush token starts at stage k in the inject cycle. It then moves one stage toward stage 0 in each following cycle.
- R4: While the token is at stage p, `kill_o[p]` and `kill_o[p-1]` are high. At p=0, only `kill_o[0]` is high.
- R5: In the cycle after the token has covered stage 0, `restart_o` is high for one cycle with no kills. `restart_pc_o` equals the address of stage k, as seen when the error was accepted, plus `ISZ`. Stage i's address is `pc_i[i*PCW +: PCW]`.
- R6: When several valid stages report errors in the same cycle, only the highest-numbered stage (the one closest to write-back) is acted on.
- R7: `commit_o` is high only when the last stage is valid, is not reporting an error, and is not being killed in that cycle.
- R8: An error that arrives while a recovery is in progress, at a stage numbered higher than the current origin, restarts the recovery from the new stage. This also suppresses any pending restart from the old recovery.
- R9: An error that arrives while a recovery is in progress, at a stage numbered at or below the current origin, has no effect on the kills, the injection, or the restart address.
- R10: An error flag on a stage whose valid bit is low is ignored.
- R11: Synchronous reset returns the controller to idle, with no kill, inject or restart active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_i | input | NSTG | Per-stage timing-error flag |
| vld_i | input | NSTG | Per-stage slot valid |
| pc_i | input | NSTG*PCW | Per-stage instruction address, stage i in bits [i*PCW +: PCW] |
| kill_o | output | NSTG | Per-stage invalidate (bubble or flush) |
| inject_o | output | 1 | Load the shadow value into the failing stage |
| inject_id_o | output | IDW | Stage that loads its shadow value |
| restart_o | output | 1 | Restart request to fetch |
| restart_pc_o | output | PCW | Address at which fetch restarts |
| commit_o | output | 1 | The last stage may commit |

## Verification
The main function is tried with:
- a single error in a middle stage;
- an error in stage 0;
- an error in the last stage.

Together these tell apart how the bubble, the inject cycle, the two-stage kill pattern and the restart timing behave at both ends of the token's path.

Further patterns cover the other rules:
- Two errors in the same cycle show whether the write-back-side error wins.
- A later error during a flush shows replacement of the recovery.
- An earlier error during a flush shows that it is ignored.
- An error on an invalid slot shows the valid qualification.

Commit gating is checked in every cycle of these patterns.

// File: rtl/frc_pkg.sv
package frc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEED     = 2'd1,
        ST_WALK     = 2'd2,
        ST_RELAUNCH = 2'd3
    } frc_state_e;
endpackage

// File: rtl/frc_pick.sv
// Chooses the valid erroring stage closest to write-back (highest index).
module frc_pick #(
    parameter int NSTG = 5,
    parameter int IDW  = 3
) (
    input  logic [NSTG-1:0] err,
    input  logic [NSTG-1:0] vld,
    output logic            hit,
    output logic [IDW-1:0]  idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NSTG; i++) begin
            if (err[i] && vld[i]) begin
                hit = 1'b1;
                idx = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/frc_killmap.sv
// Merges the same-cycle bubble and the two-stage flush window into kills.
module frc_killmap #(
    parameter int NSTG = 5,
    parameter int IDW  = 3
) (
    input  logic            train_on,
    input  logic [IDW-1:0]  pos,
    input  logic            bub_on,
    input  logic [IDW-1:0]  bub_idx,
    output logic [NSTG-1:0] kill
);
    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        logic hit_train;
        logic hit_bub;
        assign hit_train = train_on && ((int'(pos) == i) || (int'(pos) == i + 1));
        assign hit_bub   = bub_on && (int'(bub_idx) + 1 == i);
        assign kill[i]   = hit_train || hit_bub;
    end
endmodule

// File: rtl/flush_recovery_ctrl.sv
module flush_recovery_ctrl
    import frc_pkg::*;
#(
    parameter int NSTG = 5,
    parameter int PCW  = 32,
    parameter int ISZ  = 4,
    localparam int IDW = (NSTG > 1) ? $clog2(NSTG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSTG-1:0]     err_i,
    input  logic [NSTG-1:0]     vld_i,
    input  logic [NSTG*PCW-1:0] pc_i,
    output logic [NSTG-1:0]     kill_o,
    output logic                inject_o,
    output logic [IDW-1:0]      inject_id_o,
    output logic                restart_o,
    output logic [PCW-1:0]      restart_pc_o,
    output logic                commit_o
);
    frc_state_e     state, state_nx;
    logic [IDW-1:0] origin, origin_nx;
    logic [IDW-1:0] pos, pos_nx;
    logic [PCW-1:0] rpc, rpc_nx;

    logic           hit;
    logic [IDW-1:0] idx;
    logic           accept;
    logic           train_on;

    frc_pick #(.NSTG(NSTG), .IDW(IDW)) u_pick (
        .err (err_i),
        .vld (vld_i),
        .hit (hit),
        .idx (idx)
    );

    // Idle takes any valid error; mid-recovery only a later stage preempts.
    assign accept = hit && ((state == ST_IDLE) || (idx > origin));

    always_comb begin
        state_nx  = state;
        origin_nx = origin;
        pos_nx    = pos;
        rpc_nx    = rpc;
        if (accept) begin
            state_nx  = ST_SEED;
            origin_nx = idx;
            pos_nx    = idx;
            rpc_nx    = pc_i[idx*PCW +: PCW] + PCW'(ISZ);
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_SEED, ST_WALK: begin
                    if (pos == '0) begin
                        state_nx = ST_RELAUNCH;
                    end else begin
                        state_nx = ST_WALK;
                        pos_nx   = pos - IDW'(1);
                    end
                end
                ST_RELAUNCH: state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            origin <= '0;
            pos    <= '0;
            rpc    <= '0;
        end else begin
            state  <= state_nx;
            origin <= origin_nx;
            pos    <= pos_nx;
            rpc    <= rpc_nx;
        end
    end

    assign train_on = (state == ST_SEED) || (state == ST_WALK);

    frc_killmap #(.NSTG(NSTG), .IDW(IDW)) u_kill (
        .train_on (train_on),
        .pos      (pos),
        .bub_on   (accept),
        .bub_idx  (idx),
        .kill     (kill_o)
    );

    always_comb begin
        inject_o     = 1'b0;
        inject_id_o  = origin;
        restart_o    = 1'b0;
        restart_pc_o = rpc;
        unique case (state)
            ST_IDLE:     ;
            ST_SEED:     inject_o  = 1'b1;
            ST_WALK:     ;
            ST_RELAUNCH: restart_o = !accept;
            default:     ;
        endcase
    end

    assign commit_o = vld_i[NSTG-1] && !err_i[NSTG-1] && !kill_o[NSTG-1];

    // R2: shadow injection follows acceptance by one cycle
    p_inject_follows_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (inject_o && inject_id_o == $past(idx)));

    // R3: the token steps down by one stage per cycle
    p_train_step_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK && pos != '0 && !accept) |=> (pos == $past(pos) - IDW'(1)));

    // R4: while injecting, the origin stage is invalidated
    p_inject_kills_origin_r4: assert property (@(posedge clk) disable iff (rst)
        inject_o |-> kill_o[inject_id_o]);

    // R5: the restart cycle carries no kills
    p_restart_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> (kill_o == '0));

    // R5: the restart request lasts one cycle
    p_restart_single_r5: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !restart_o);

    // R11: nothing is active in the cycle after reset
    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!inject_o && !restart_o));
endmodule

// File: tb/flush_recovery_ctrl_tb.sv
module flush_recovery_ctrl_tb;
    localparam int NSTG = 5;
    localparam int PCW  = 32;
    localparam int ISZ  = 4;
    localparam int IDW  = 3;

    logic                clk = 1'b0;
    logic                rst;
    logic [NSTG-1:0]     err_i;
    logic [NSTG-1:0]     vld_i;
    logic [NSTG*PCW-1:0] pc_i;
    logic [NSTG-1:0]     kill_o;
    logic                inject_o;
    logic [IDW-1:0]      inject_id_o;
    logic                restart_o;
    logic [PCW-1:0]      restart_pc_o;
    logic                commit_o;

    always #2 clk = ~clk;

    flush_recovery_ctrl #(.NSTG(NSTG), .PCW(PCW), .ISZ(ISZ)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .err_i        (err_i),
        .vld_i        (vld_i),
        .pc_i         (pc_i),
        .kill_o       (kill_o),
        .inject_o     (inject_o),
        .inject_id_o  (inject_id_o),
        .restart_o    (restart_o),
        .restart_pc_o (restart_pc_o),
        .commit_o     (commit_o)
    );

    typedef struct {
        logic [NSTG-1:0] kill;
        logic            inj;
        logic [IDW-1:0]  id;
        logic            rst_q;
        logic [PCW-1:0]  pc;
        logic            com;
        string           tag;
    } exp_t;

    exp_t queue_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;
    event smp_ev;

    function automatic logic [PCW-1:0] rpc_of(int k);
        return 32'h1000 + PCW'(k) * 32'h10 + PCW'(ISZ);
    endfunction

    // Monitor: pops one expected item per sampled cycle and compares it.
    initial begin
        forever begin
            @(smp_ev);
            if (queue_q.size() != 0) begin
                exp_t e;
                bit bad;
                e = queue_q.pop_front();
                bad = (kill_o !== e.kill) || (inject_o !== e.inj) ||
                      (restart_o !== e.rst_q) || (commit_o !== e.com) ||
                      (e.inj && inject_id_o !== e.id) ||
                      (e.rst_q && restart_pc_o !== e.pc);
                n_cmp++;
                if (bad) begin
                    n_bad++;
                    $display("FAIL %s: got kill=%b inj=%b id=%0d rst=%b pc=%h com=%b exp kill=%b inj=%b id=%0d rst=%b pc=%h com=%b",
                             e.tag, kill_o, inject_o, inject_id_o, restart_o, restart_pc_o, commit_o,
                             e.kill, e.inj, e.id, e.rst_q, e.pc, e.com);
                end
            end
        end
    end

    // Driver: applies one cycle of stimulus and queues its expected outputs.
    task automatic step(input logic [NSTG-1:0] err, input logic [NSTG-1:0] vld,
                        input logic [NSTG-1:0] ekill, input logic einj, input int eid,
                        input logic erst, input logic [PCW-1:0] epc, input logic ecom,
                        input string tag);
        exp_t e;
        @(negedge clk);
        err_i = err;
        vld_i = vld;
        e.kill = ekill; e.inj = einj; e.id = IDW'(eid);
        e.rst_q = erst; e.pc = epc; e.com = ecom; e.tag = tag;
        queue_q.push_back(e);
        #1;
        ->smp_ev;
        #0;
    endtask

    localparam logic [NSTG-1:0] ALL = 5'b11111;

    initial begin
        for (int i = 0; i < NSTG; i++) pc_i[i*PCW +: PCW] = 32'h1000 + 32'h10 * i;
        err_i = '0;
        vld_i = ALL;
        rst   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R11 reset idle");

        // Single error in middle stage 2
        step(5'b00100, ALL, 5'b01000, 0, 0, 0, 0, 1, "R1 bubble k2");
        step('0, ALL, 5'b00110, 1, 2, 0, 0, 1, "R2 R4 inject k2");
        step('0, ALL, 5'b00011, 0, 0, 0, 0, 1, "R3 walk p1");
        step('0, ALL, 5'b00001, 0, 0, 0, 0, 1, "R4 walk p0");
        step('0, ALL, 5'b00000, 0, 0, 1, rpc_of(2), 1, "R5 restart k2");
        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R5 single restart");

        // Two errors together: stage 3 wins
        step(5'b01010, ALL, 5'b10000, 0, 0, 0, 0, 0, "R6 R7 winner bubble");
        step('0, ALL, 5'b01100, 1, 3, 0, 0, 1, "R6 inject k3");
        step('0, ALL, 5'b00110, 0, 0, 0, 0, 1, "R3 p2");
        step('0, ALL, 5'b00011, 0, 0, 0, 0, 1, "R3 p1");
        step('0, ALL, 5'b00001, 0, 0, 0, 0, 1, "R4 p0");
        step('0, ALL, 5'b00000, 0, 0, 1, rpc_of(3), 1, "R5 R6 restart k3");
        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R5 idle");

        // Error in the last stage
        step(5'b10000, ALL, 5'b00000, 0, 0, 0, 0, 0, "R1 R7 last stage no bubble");
        step('0, ALL, 5'b11000, 1, 4, 0, 0, 0, "R7 inject k4 kill last");
        step('0, ALL, 5'b01100, 0, 0, 0, 0, 1, "R3 p3");
        step('0, ALL, 5'b00110, 0, 0, 0, 0, 1, "R3 p2");
        step('0, ALL, 5'b00011, 0, 0, 0, 0, 1, "R3 p1");
        step('0, ALL, 5'b00001, 0, 0, 0, 0, 1, "R4 p0");
        step('0, ALL, 5'b00000, 0, 0, 1, rpc_of(4), 1, "R5 restart k4");
        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R5 idle");

        // Error in stage 0
        step(5'b00001, ALL, 5'b00010, 0, 0, 0, 0, 1, "R1 bubble k0");
        step('0, ALL, 5'b00001, 1, 0, 0, 0, 1, "R4 inject k0");
        step('0, ALL, 5'b00000, 0, 0, 1, rpc_of(0), 1, "R5 restart k0");
        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R5 idle");

        // Error on invalid slot
        step(5'b00100, 5'b11011, 5'b00000, 0, 0, 0, 0, 1, "R10 invalid error");
        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R10 no inject");

        // Later error preempts
        step(5'b00010, ALL, 5'b00100, 0, 0, 0, 0, 1, "R1 bubble k1");
        step(5'b01000, ALL, 5'b10011, 1, 1, 0, 0, 0, "R8 preempt bubble");
        step('0, ALL, 5'b01100, 1, 3, 0, 0, 1, "R8 inject k3");
        step('0, ALL, 5'b00110, 0, 0, 0, 0, 1, "R8 p2");
        step('0, ALL, 5'b00011, 0, 0, 0, 0, 1, "R8 p1");
        step('0, ALL, 5'b00001, 0, 0, 0, 0, 1, "R8 p0");
        step('0, ALL, 5'b00000, 0, 0, 1, rpc_of(3), 1, "R8 restart k3");
        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R8 idle");

        // Earlier error ignored
        step(5'b01000, ALL, 5'b10000, 0, 0, 0, 0, 0, "R1 bubble k3");
        step(5'b00100, ALL, 5'b01100, 1, 3, 0, 0, 1, "R9 earlier ignored");
        step('0, ALL, 5'b00110, 0, 0, 0, 0, 1, "R9 p2");
        step('0, ALL, 5'b00011, 0, 0, 0, 0, 1, "R9 p1");
        step('0, ALL, 5'b00001, 0, 0, 0, 0, 1, "R9 p0");
        step('0, ALL, 5'b00000, 0, 0, 1, rpc_of(3), 1, "R9 restart pc kept");
        step('0, ALL, 5'b00000, 0, 0, 0, 0, 1, "R9 idle");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule